// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block converts single host requests into timed NAND flash bus cycles. A request is one of four kinds: command latch, address latch, data write or data read. The host offers it with a valid/ready handshake, and only one request is in flight at a time. Each access runs through three timed phases: setup, strobe and hold. During setup the latch lines and the outgoing byte or word are presented. During the strobe phase the write-enable or read-enable line is pulsed. During hold the same values stay on the pins after the strobe has been released. When the hold phase ends, a one-cycle done pulse is raised, and for a read it carries the captured data.

A small configuration register set holds the phase lengths, the selected chip-select bank and the bus width. Most lengths use an "encoded value plus one" rule. The write-only tristate window counts exactly the programmed value. A read's setup phase depends on the access that came before it: it uses the command-to-read delay after a command, the address-to-read delay after an address, and the general setup length otherwise. The device's active-low wait input is synchronized on chip and stretches the strobe phase. Configuration writes go into live registers, and the live registers are copied into an active set when a request is accepted. A rewrite during an access therefore never disturbs that access.

Top module: `nand_seq`

## Requirements
- R1: Request type codes are 0 command, 1 address, 2 data write and 3 data read. Throughout an access, nand_cle_o is high only for type 0 and nand_ale_o is high only for type 1. Both are low for data accesses and while idle.
- R2: For command, address and write accesses, the setup phase lasts tset+1 cycles (1 to 256). During setup the chip enable is low and both enables are high.
- R3: With the wait input high, the strobe phase lasts twait+1 cycles. Writes (types 0 to 2) pulse nand_we_no and reads pulse nand_re_no, and the two are never low together.
- R4: After the strobe ends, the hold phase keeps chip enable low, the latch line and the driven data unchanged for thold+1 cycles.
- R5: On a data write, nand_dq_oe_o stays low for exactly thiz cycles from the first cycle of the access, then stays high until the access ends. Command and address accesses drive from the first cycle. Reads never drive.
- R6: A read's setup phase lasts tclr+1 cycles if the previous access was a command, and tar+1 cycles if the previous access was an address. In every other case, including the first access after reset, it lasts tset+1 cycles.
- R7: nand_wait_ni passes through a two-flop synchronizer. While the synchronized value is low, the strobe is held and its count restarts. If the wait input is released after K strobe cycles, the strobe lasts K+twait+2 cycles.
- R8: During an access, only nand_ce_no[bank] is low, where bank is the configured bank (0 to 3). The bank is 0 after reset.
- R9: When wide is 0 (the reset value), bits 15:8 of driven data and of returned read data are zero. When wide is 1, the full 16-bit word is used. Command and address cycles always drive zero in bits 15:8.
- R10: req_ready_o is high only while idle. done_o is a one-cycle pulse in the cycle after the last hold cycle. On a read, rd_data_o then holds nand_dq_i as sampled at the end of the strobe.
- R11: A configuration write during an access does not change that access. It takes effect from the next request.
- R12: While in reset and after it, the outputs show idle: latch lines low, all chip enables high, both enables high, bus not driven, ready high and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the configuration fields |
| cfg_tset_i | input | 8 | Setup length, encoded minus one |
| cfg_thold_i | input | 8 | Hold length, encoded minus one |
| cfg_twait_i | input | 8 | Strobe length, encoded minus one |
| cfg_thiz_i | input | 8 | Write tristate window, in cycles |
| cfg_tclr_i | input | 4 | Read setup after a command, encoded minus one |
| cfg_tar_i | input | 4 | Read setup after an address, encoded minus one |
| cfg_wide_i | input | 1 | 1 selects a 16-bit device bus |
| cfg_bank_i | input | 2 | Chip-select bank |
| req_valid_i | input | 1 | Request offered |
| req_type_i | input | 2 | Request kind (see R1) |
| req_data_i | input | 16 | Command, address or write data |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| done_o | output | 1 | Access finished pulse |
| rd_data_o | output | 16 | Captured read data |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_ce_no | output | 4 | Chip enables, active low |
| nand_we_no | output | 1 | Write enable, active low |
| nand_re_no | output | 1 | Read enable, active low |
| nand_dq_o | output | 16 | Data bus output value |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 16 | Data bus input value |
| nand_wait_ni | input | 1 | Device wait, active low |

## Verification
The bench builds the block with its default settings: four banks, a 16-bit bus, 8-bit phase fields and a two-stage synchronizer. With these defaults, both extremes of every encoded field can be reached, including a 256-cycle setup and a 256-cycle hold. The bench measures phase lengths at the pins. It runs sequences in which each read follows a command, an address, a write, another read, or a reset, and it releases the wait input at a known strobe cycle to expose the synchronizer latency. The tristate window is set both shorter and longer than the setup phase.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int TIME_W = 8;
  localparam int RD_W   = 4;
  localparam int NBANK  = 4;
  localparam int BANK_W = $clog2(NBANK);
  localparam int BUS_W  = 16;

  typedef enum logic [1:0] {REQ_CMD = 2'd0, REQ_ADDR = 2'd1, REQ_WR = 2'd2, REQ_RD = 2'd3} req_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;
  typedef enum logic [1:0] {LAST_NONE, LAST_CMD, LAST_ADDR} last_e;

  typedef struct packed {
    logic [TIME_W-1:0] tset;
    logic [TIME_W-1:0] thold;
    logic [TIME_W-1:0] twait;
    logic [TIME_W-1:0] thiz;
    logic [RD_W-1:0]   tclr;
    logic [RD_W-1:0]   tar;
    logic              wide;
    logic [BANK_W-1:0] bank;
  } cfg_t;
endpackage

// File: rtl/nand_seq_cfg.sv
module nand_seq_cfg
  import nand_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  cfg_t wr_i,
  input  logic take_i,
  output cfg_t live_o,
  output cfg_t act_o
);
  cfg_t live_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      act_q  <= '0;
    end else begin
      if (we_i)   live_q <= wr_i;
      if (take_i) act_q  <= live_q;
    end
  end

  assign live_o = live_q;
  assign act_o  = act_q;

  p_act_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(act_o));
endmodule

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/nand_seq_bank.sv
module nand_seq_bank
  import nand_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [NBANK-1:0]  ce_no
);
  for (genvar i = 0; i < NBANK; i++) begin : g_ce
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ce_no[i] <= 1'b1;
      else         ce_no[i] <= !(en_i && bank_i == BANK_W'(i));
    end
  end

  p_ce_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ce_no));
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  req_e              req_type_i,
  input  logic [BUS_W-1:0]  req_data_i,
  input  logic [TIME_W-1:0] live_thiz_i,
  input  logic              live_wide_i,
  input  logic [BANK_W-1:0] live_bank_i,
  input  cfg_t              act_i,
  input  logic              go_i,
  input  logic [BUS_W-1:0]  dq_i,
  output logic              ready_o,
  output logic              take_o,
  output logic              busy_nxt_o,
  output logic [BANK_W-1:0] bank_nxt_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic              dq_oe_o,
  output logic [BUS_W-1:0]  dq_o,
  output logic              done_o,
  output logic [BUS_W-1:0]  rd_data_o
);
  localparam int HALF = BUS_W / 2;

  function automatic logic [BUS_W-1:0] narrow(input logic [BUS_W-1:0] d);
    return {{(BUS_W-HALF){1'b0}}, d[HALF-1:0]};
  endfunction

  phase_e            phase_q, phase_d;
  req_e              type_q, typ_d;
  last_e             last_q;
  logic [TIME_W-1:0] cnt_q, cnt_d, setup_end, hz_q;
  logic [BUS_W-1:0]  data_q;
  logic              accept, busy_d, last_strobe, leave_hold, oe_d;
  logic              cle_q, ale_q, we_nq, re_nq, oe_q, done_q;
  logic [BUS_W-1:0]  rd_q;

  assign accept = req_valid_i && phase_q == PH_IDLE;
  assign typ_d  = accept ? req_type_i : type_q;

  // read setup length depends on the latch that preceded it
  always_comb begin
    setup_end = act_i.tset;
    if (type_q == REQ_RD) begin
      unique case (last_q)
        LAST_CMD:  setup_end = TIME_W'(act_i.tclr);
        LAST_ADDR: setup_end = TIME_W'(act_i.tar);
        default:   setup_end = act_i.tset;
      endcase
    end
  end

  assign last_strobe = phase_q == PH_STROBE && go_i && cnt_q == act_i.twait;
  assign leave_hold  = phase_q == PH_HOLD && cnt_q == act_i.thold;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (accept) phase_d = PH_SETUP;
      end
      PH_SETUP: if (cnt_q == setup_end) begin
        phase_d = PH_STROBE;
        cnt_d   = '0;
      end
      PH_STROBE: begin
        if (!go_i) cnt_d = '0;
        else if (last_strobe) begin
          phase_d = PH_HOLD;
          cnt_d   = '0;
        end
      end
      PH_HOLD: if (leave_hold) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign busy_d = phase_d != PH_IDLE;

  always_comb begin
    oe_d = 1'b0;
    if (busy_d) begin
      if (accept)
        oe_d = req_type_i == REQ_CMD || req_type_i == REQ_ADDR ||
               (req_type_i == REQ_WR && live_thiz_i == '0);
      else if (type_q == REQ_WR)
        oe_d = oe_q || hz_q >= act_i.thiz;
      else
        oe_d = oe_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      type_q  <= REQ_CMD;
      last_q  <= LAST_NONE;
      hz_q    <= '0;
      data_q  <= '0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      we_nq   <= 1'b1;
      re_nq   <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (accept) begin
        type_q <= req_type_i;
        hz_q   <= TIME_W'(1);
        data_q <= (req_type_i == REQ_WR && live_wide_i) ? req_data_i : narrow(req_data_i);
      end else if (hz_q != '1) begin
        hz_q <= hz_q + 1'b1;
      end
      if (leave_hold)
        last_q <= type_q == REQ_CMD  ? LAST_CMD :
                  type_q == REQ_ADDR ? LAST_ADDR : LAST_NONE;
      if (last_strobe && type_q == REQ_RD)
        rd_q <= act_i.wide ? dq_i : narrow(dq_i);
      cle_q  <= busy_d && typ_d == REQ_CMD;
      ale_q  <= busy_d && typ_d == REQ_ADDR;
      we_nq  <= !(phase_d == PH_STROBE && typ_d != REQ_RD);
      re_nq  <= !(phase_d == PH_STROBE && typ_d == REQ_RD);
      oe_q   <= oe_d;
      done_q <= leave_hold;
    end
  end

  assign ready_o    = phase_q == PH_IDLE;
  assign take_o     = accept;
  assign busy_nxt_o = busy_d;
  assign bank_nxt_o = accept ? live_bank_i : act_i.bank;
  assign cle_o      = cle_q;
  assign ale_o      = ale_q;
  assign we_no      = we_nq;
  assign re_no      = re_nq;
  assign dq_oe_o    = oe_q;
  assign dq_o       = data_q;
  assign done_o     = done_q;
  assign rd_data_o  = rd_q;

  p_latch_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  p_one_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  p_hold_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && phase_d == PH_HOLD) |=>
      ($stable(dq_o) && $stable(cle_o) && $stable(ale_o) && $stable(dq_oe_o)));
  p_rd_no_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && type_q == REQ_RD) |-> !dq_oe_o);
  p_wait_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && !go_i) |=> phase_q == PH_STROBE);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (we_no && re_no && !dq_oe_o && !cle_o && !ale_o));
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [TIME_W-1:0] cfg_tset_i,
  input  logic [TIME_W-1:0] cfg_thold_i,
  input  logic [TIME_W-1:0] cfg_twait_i,
  input  logic [TIME_W-1:0] cfg_thiz_i,
  input  logic [RD_W-1:0]   cfg_tclr_i,
  input  logic [RD_W-1:0]   cfg_tar_i,
  input  logic              cfg_wide_i,
  input  logic [BANK_W-1:0] cfg_bank_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_type_i,
  input  logic [BUS_W-1:0]  req_data_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic [NBANK-1:0]  nand_ce_no,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [BUS_W-1:0]  nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [BUS_W-1:0]  nand_dq_i,
  input  logic              nand_wait_ni
);
  cfg_t              wr_cfg, live_cfg, act_cfg;
  logic              take, busy_nxt, go;
  logic [BANK_W-1:0] bank_nxt;

  assign wr_cfg = '{tset: cfg_tset_i, thold: cfg_thold_i, twait: cfg_twait_i,
                    thiz: cfg_thiz_i, tclr: cfg_tclr_i, tar: cfg_tar_i,
                    wide: cfg_wide_i, bank: cfg_bank_i};

  nand_seq_cfg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wr_i(wr_cfg), .take_i(take),
    .live_o(live_cfg), .act_o(act_cfg)
  );

  nand_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(nand_wait_ni), .q_o(go)
  );

  nand_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_type_i(req_e'(req_type_i)), .req_data_i,
    .live_thiz_i(live_cfg.thiz), .live_wide_i(live_cfg.wide), .live_bank_i(live_cfg.bank),
    .act_i(act_cfg), .go_i(go), .dq_i(nand_dq_i),
    .ready_o(req_ready_o), .take_o(take), .busy_nxt_o(busy_nxt), .bank_nxt_o(bank_nxt),
    .cle_o(nand_cle_o), .ale_o(nand_ale_o), .we_no(nand_we_no), .re_no(nand_re_no),
    .dq_oe_o(nand_dq_oe_o), .dq_o(nand_dq_o), .done_o, .rd_data_o
  );

  nand_seq_bank u_bank (
    .clk_i, .rst_ni, .en_i(busy_nxt), .bank_i(bank_nxt), .ce_no(nand_ce_no)
  );
endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RD_PAT = 16'hC35A;

  typedef struct packed {
    logic [1:0]  typ;
    logic [1:0]  bank;
    logic        wide;
    logic [7:0]  tset;
    logic [7:0]  twait;
    logic [7:0]  thold;
    logic [7:0]  thiz;
    logic [3:0]  tclr;
    logic [3:0]  tar;
    logic [15:0] data;
    logic [8:0]  e_setup;
    logic [8:0]  e_strobe;
    logic [8:0]  e_hold;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b0, 8'd2,   8'd1, 8'd0,   8'd0, 4'd3,  4'd5,  16'hAB70, 9'd3,   9'd2, 9'd1},
    '{2'd3, 2'd0, 1'b0, 8'd7,   8'd1, 8'd0,   8'd0, 4'd3,  4'd5,  16'h0000, 9'd4,   9'd2, 9'd1},
    '{2'd1, 2'd2, 1'b0, 8'd0,   8'd0, 8'd3,   8'd0, 4'd3,  4'd5,  16'h0012, 9'd1,   9'd1, 9'd4},
    '{2'd3, 2'd2, 1'b1, 8'd7,   8'd2, 8'd1,   8'd0, 4'd3,  4'd5,  16'h0000, 9'd6,   9'd3, 9'd2},
    '{2'd2, 2'd3, 1'b1, 8'd4,   8'd0, 8'd2,   8'd3, 4'd0,  4'd0,  16'hBEEF, 9'd5,   9'd1, 9'd3},
    '{2'd3, 2'd3, 1'b1, 8'd1,   8'd0, 8'd0,   8'd0, 4'd15, 4'd15, 16'h0000, 9'd2,   9'd1, 9'd1},
    '{2'd2, 2'd1, 1'b0, 8'd0,   8'd0, 8'd0,   8'd0, 4'd0,  4'd0,  16'h1234, 9'd1,   9'd1, 9'd1},
    '{2'd0, 2'd1, 1'b1, 8'd1,   8'd0, 8'd1,   8'd5, 4'd0,  4'd0,  16'hFF90, 9'd2,   9'd1, 9'd2},
    '{2'd2, 2'd0, 1'b0, 8'd2,   8'd3, 8'd1,   8'd7, 4'd0,  4'd0,  16'h5A3C, 9'd3,   9'd4, 9'd2},
    '{2'd3, 2'd0, 1'b0, 8'd9,   8'd0, 8'd0,   8'd0, 4'd1,  4'd1,  16'h0000, 9'd10,  9'd1, 9'd1},
    '{2'd3, 2'd0, 1'b1, 8'd0,   8'd4, 8'd0,   8'd0, 4'd1,  4'd1,  16'h0000, 9'd1,   9'd5, 9'd1},
    '{2'd1, 2'd1, 1'b0, 8'd255, 8'd0, 8'd255, 8'd0, 4'd0,  4'd0,  16'h00C3, 9'd256, 9'd1, 9'd256}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_tset = '0, cfg_thold = '0, cfg_twait = '0, cfg_thiz = '0;
  logic [3:0]  cfg_tclr = '0, cfg_tar = '0;
  logic        cfg_wide = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = '0;
  logic [15:0] req_data = '0;
  logic        req_ready, done;
  logic [15:0] rd_data;
  logic        cle, ale, we_n, re_n, dq_oe;
  logic [3:0]  ce_n;
  logic [15:0] dq_out;
  logic [15:0] dq_in = RD_PAT;
  logic        wait_n = 1'b1;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_seq u_nand_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we),
    .cfg_tset_i(cfg_tset), .cfg_thold_i(cfg_thold), .cfg_twait_i(cfg_twait),
    .cfg_thiz_i(cfg_thiz), .cfg_tclr_i(cfg_tclr), .cfg_tar_i(cfg_tar),
    .cfg_wide_i(cfg_wide), .cfg_bank_i(cfg_bank),
    .req_valid_i(req_valid), .req_type_i(req_type), .req_data_i(req_data),
    .req_ready_o(req_ready), .done_o(done), .rd_data_o(rd_data),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_ce_no(ce_n),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_out),
    .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_in), .nand_wait_ni(wait_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(!cle && !ale, req, {cle, ale}, 0);
    chk(ce_n == 4'hF, req, ce_n, 4'hF);
    chk(we_n && re_n, req, {we_n, re_n}, 3);
    chk(!dq_oe, req, dq_oe, 0);
    chk(req_ready && !done, req, {req_ready, done}, 2);
  endtask

  task automatic access(input vec_t v, input bit wr_cfg, input int wait_k, input bit mid_cfg);
    int ns = 0, nw = 0, nh = 0, nz = 0, it = 0;
    bit seen_strobe = 0, oe_on = 0, mid_done = 0;
    bit ok_lat = 1, ok_ce = 1, ok_dq = 1, ok_hs = 1, ok_kind = 1, ok_oe = 1;
    logic [15:0] edq, erd;
    logic [3:0]  ece;
    edq = (v.typ == 2'd2 && v.wide) ? v.data : {8'h00, v.data[7:0]};
    erd = v.wide ? RD_PAT : {8'h00, RD_PAT[7:0]};
    ece = ~(4'b0001 << v.bank);
    if (wr_cfg) begin
      @(negedge clk);
      cfg_tset = v.tset; cfg_twait = v.twait; cfg_thold = v.thold; cfg_thiz = v.thiz;
      cfg_tclr = v.tclr; cfg_tar = v.tar; cfg_wide = v.wide; cfg_bank = v.bank;
      cfg_we = 1'b1;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    wait_n = (wait_k == 0);
    req_valid = 1'b1; req_type = v.typ; req_data = v.data;
    @(negedge clk);
    req_valid = 1'b0;
    while (ce_n != 4'hF && it < 3000) begin
      cfg_we = 1'b0;
      if (!we_n || !re_n) begin
        nw++;
        seen_strobe = 1;
        if (v.typ == 2'd3 ? !we_n : !re_n) ok_kind = 0;
        if (wait_k > 0 && nw == wait_k) wait_n = 1'b1;
      end else if (!seen_strobe) ns++;
      else nh++;
      if (cle != (v.typ == 2'd0) || ale != (v.typ == 2'd1)) ok_lat = 0;
      if (ce_n != ece) ok_ce = 0;
      if (req_ready || done) ok_hs = 0;
      if (v.typ == 2'd3) begin
        if (dq_oe) ok_oe = 0;
      end else if (!dq_oe) begin
        if (oe_on) ok_oe = 0;
        else nz++;
      end else begin
        oe_on = 1;
        if (dq_out != edq) ok_dq = 0;
      end
      if (mid_cfg && !mid_done && ns == 1 && !seen_strobe) begin
        cfg_tset = 8'd9; cfg_bank = 2'd3; cfg_we = 1'b1;
        mid_done = 1;
      end
      it++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    chk(ok_lat, "R1 latch lines", {cle, ale}, v.typ);
    chk(ns == v.e_setup, v.typ == 2'd3 ? "R6 read setup" : "R2 setup", ns, v.e_setup);
    chk(nw == v.e_strobe, wait_k > 0 ? "R7 wait strobe" : "R3 strobe", nw, v.e_strobe);
    chk(ok_kind, "R3 strobe kind", we_n, re_n);
    chk(nh == v.e_hold, "R4 hold", nh, v.e_hold);
    chk(ok_oe && nz == (v.typ == 2'd2 ? int'(v.thiz) : 0), "R5 drive window", nz, v.thiz);
    chk(ok_dq, "R9 driven data", dq_out, edq);
    chk(ok_ce, "R8 chip enable", ce_n, ece);
    chk(ok_hs, "R10 ready low while busy", req_ready, 0);
    chk(done && req_ready, "R10 done pulse", {done, req_ready}, 3);
    if (v.typ == 2'd3) chk(rd_data == erd, "R10 R9 read data", rd_data, erd);
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    check_idle("R12 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R12 after reset");

    // R6: first read after reset uses tset; R8 bank 0 default
    cfg_tset = 8'd3; cfg_twait = '0; cfg_thold = '0; cfg_tclr = '0; cfg_tar = '0;
    @(negedge clk); cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    d = '{2'd3, 2'd0, 1'b0, 8'd3, 8'd0, 8'd0, 8'd0, 4'd0, 4'd0, 16'h0, 9'd4, 9'd1, 9'd1};
    access(d, 1'b0, 0, 1'b0);

    for (int i = 0; i < NV; i++) access(VECS[i], 1'b1, 0, 1'b0);

    // R7: wait released after 3 strobe cycles, twait=1 -> 3+1+2
    d = '{2'd2, 2'd2, 1'b0, 8'd1, 8'd1, 8'd0, 8'd0, 4'd0, 4'd0, 16'h0077, 9'd2, 9'd6, 9'd1};
    access(d, 1'b1, 3, 1'b0);

    // R11: rewrite tset/bank mid-access, takes effect next request
    d = '{2'd0, 2'd0, 1'b0, 8'd2, 8'd0, 8'd0, 8'd0, 4'd0, 4'd0, 16'h0031, 9'd3, 9'd1, 9'd1};
    access(d, 1'b1, 0, 1'b1);
    d = '{2'd0, 2'd3, 1'b0, 8'd9, 8'd0, 8'd0, 8'd0, 4'd0, 4'd0, 16'h0031, 9'd10, 9'd1, 9'd1};
    access(d, 1'b0, 0, 1'b0);

    @(negedge clk);
    check_idle("R12 idle at end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule